// File: doc/BRIEF.md
# Pixel to Bus Cycle Packer

This block sits between a pixel stream and the strobe engine of a narrow parallel display bus. It takes pixels of 12, 16, 18 or 24 bits over a valid/ready handshake and slices them into bus words for a bus of 8, 9, 12 or 16 data lines. Every pixel is cut most significant bit first into slices as wide as the bus. One pixel may therefore need one, two or three bus cycles. When the pixel is one and a half bus widths wide, two pixels share three cycles, and the middle cycle carries the tail of the first pixel and the head of the second. The cycle format is not programmed. It follows from the pixel size and the line count.

Software loads the pixel size, the line count and the frame pixel count (width times height) while the block is idle. It then writes a control word that sets the enable, picks a chip select and says whether to start at once or wait for an external trigger pulse. The block takes exactly the programmed number of pixels and drains every bus word. It then pulses frame done for one cycle and clears its own enable. Clearing the enable in the middle of a frame drops any half-sent pixel.

Top module: `pixel_bus_packer`

## Requirements
- R1: After reset, bus_valid, pix_ready and frame_done are 0 and ctrl_rd reads 0.
- R2: cfg_kind selects the pixel size: 0 = 12, 1 = 16, 2 = 18, 3 = 24 bits. cfg_lanes selects the line count: 0 = 8, 1 = 9, 2 = 12, 3 = 16. Only the low pixel-size bits of pix_data are used, and the upper bits have no effect on any bus word.
- R3: Pixels are sent most significant bit first, one line-count-wide slice per bus word. Each slice sits on bus_data lines L-1:0 and the lines above L are 0. A 16-bit pixel on 8 lines goes out as bits 15:8 and then 7:0. A 24-bit pixel on 8 lines goes out as 23:16, 15:8 and then 7:0.
- R4: When the pixel is 1.5 times the line count, each pair of pixels A, B takes three words: A's top L bits, then A's low L/2 bits in the upper half with B's top L/2 bits in the lower half, then B's low L bits.
- R5: In that paired format, an odd last pixel of a frame is flushed as a final word whose lower half is 0.
- R6: Each frame accepts exactly cfg_count pixels, counted from the write that sets the enable. pix_ready stays 0 after the last one.
- R7: frame_done is high for exactly one cycle, starting on the second clock edge after the handshake of the frame's last bus word. On that same edge ctrl_rd bit 0 reads 0.
- R8: Control word bit 0 is enable, bits 3:2 are the chip select and bit 4 starts the frame at once. ctrl_rd returns these fields in the same positions with the other bits 0, and bus_cs carries bits 3:2.
- R9: With bit 4 clear, no pixel is accepted and no word is offered until an ext_trig pulse arrives while the block is enabled.
- R10: Configuration writes while enabled are ignored. The running frame keeps its pixel size, line count and pixel count.
- R11: Writing enable 0 mid-frame drops any partly sent pixel. bus_valid falls, and the next frame starts from the first slice of a new pixel.
- R12: While bus_valid is high and bus_ready is low, the word holds steady and bus_valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word: enable, chip select, start now |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_kind | input | 2 | Pixel size code |
| cfg_lanes | input | 2 | Bus line count code |
| cfg_count | input | CNT_W | Pixels per frame |
| ext_trig | input | 1 | External start pulse |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 24 | Pixel value, low bits used |
| pix_ready | output | 1 | Pixel taken this cycle when valid |
| bus_valid | output | 1 | Bus word offered |
| bus_data | output | 16 | Bus word on lines L-1:0 |
| bus_cs | output | 2 | Chip select for the word |
| bus_ready | input | 1 | Strobe engine takes the word |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| ctrl_rd | output | 8 | Control word readback |

## Verification
The slicing is tried on every legal pairing of pixel size and line count with random pixel values whose unused upper bits are also random. Whole slices, halves and thirds of a pixel, and words that straddle two pixels, are all checked against a reference stream built bit by bit. Odd pixel counts in the paired format separate a correct zero-padded flush from a lost or merged tail. Random bus_ready gaps show whether words are held steady. Directed runs cover the trigger wait, configuration writes during a frame and a mid-pixel disable, which show whether state leaks into the next frame.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;
  localparam int PIX_W  = 24;
  localparam int BUS_W  = 16;
  localparam int SR_W   = 2 * PIX_W;
  localparam int FILL_W = $clog2(SR_W + 1);
  localparam int SZ_W   = $clog2(PIX_W + 1);

  typedef enum logic [1:0] {PK12 = 2'd0, PK16 = 2'd1, PK18 = 2'd2, PK24 = 2'd3} pix_kind_e;
  typedef enum logic [1:0] {LN8 = 2'd0, LN9 = 2'd1, LN12 = 2'd2, LN16 = 2'd3} lanes_e;

  function automatic logic [SZ_W-1:0] pix_bits(pix_kind_e k);
    case (k)
      PK12:    return SZ_W'(12);
      PK16:    return SZ_W'(16);
      PK18:    return SZ_W'(18);
      default: return SZ_W'(24);
    endcase
  endfunction

  function automatic logic [SZ_W-1:0] bus_lines(lanes_e l);
    case (l)
      LN8:     return SZ_W'(8);
      LN9:     return SZ_W'(9);
      LN12:    return SZ_W'(12);
      default: return SZ_W'(16);
    endcase
  endfunction

  // left-align a pixel in the shifter and move it below the bits already held
  function automatic logic [SR_W-1:0] place_px(logic [PIX_W-1:0] px, logic [SZ_W-1:0] p,
                                               logic [FILL_W-1:0] fill);
    logic [PIX_W-1:0] m;
    logic [SR_W-1:0]  left;
    m    = px & ((PIX_W'(1) << p) - PIX_W'(1));
    left = {m, {PIX_W{1'b0}}} << (SZ_W'(PIX_W) - p);
    return left >> fill;
  endfunction

  // top slice of the shifter, right-justified onto the low l lines
  function automatic logic [BUS_W-1:0] slice_word(logic [BUS_W-1:0] top, logic [SZ_W-1:0] l);
    return top >> (SZ_W'(BUS_W) - l);
  endfunction
endpackage

// File: rtl/pxpk_regs.sv
module pxpk_regs
  import pxpk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [1:0]       cfg_lanes,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             ext_trig,
  input  logic             done_evt,
  output logic             en,
  output logic             run,
  output logic             start_load,
  output logic [1:0]       cs,
  output pix_kind_e        kind,
  output lanes_e           lanes,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       ctrl_rd
);
  logic force_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      force_q <= 1'b0;
      cs      <= 2'd0;
    end else if (ctrl_we) begin
      en      <= ctrl_wdata[0];
      cs      <= ctrl_wdata[3:2];
      force_q <= ctrl_wdata[4];
    end else if (done_evt) begin
      en      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (!en)      armed_q <= 1'b0;
    else if (ext_trig) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= PK12;
      lanes <= LN8;
      count <= '0;
    end else if (cfg_we && !en) begin
      kind  <= pix_kind_e'(cfg_kind);
      lanes <= lanes_e'(cfg_lanes);
      count <= cfg_count;
    end
  end

  assign run        = en && (force_q || armed_q);
  assign start_load = ctrl_we && ctrl_wdata[0] && !en;
  assign ctrl_rd    = {3'b000, force_q, cs, 1'b0, en};

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(kind) && $stable(lanes) && $stable(count)));

  assert_done_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !ctrl_we) |=> !en);
endmodule

// File: rtl/pxpk_frame_cnt.sv
module pxpk_frame_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_load,
  input  logic [CNT_W-1:0] count,
  input  logic             pix_fire,
  input  logic             run,
  input  logic             fill_zero,
  output logic             rem_zero,
  output logic             done_evt,
  output logic             frame_done
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= done_evt;
      if (start_load)    rem_q <= count;
      else if (pix_fire) rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign rem_zero = (rem_q == '0);
  assign done_evt = run && rem_zero && fill_zero;

  assert_no_extra_pixel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fire |-> !rem_zero);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/pxpk_shifter.sv
module pxpk_shifter
  import pxpk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             rem_zero,
  input  pix_kind_e        kind,
  input  lanes_e           lanes,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             pix_fire,
  input  logic             bus_ready,
  output logic             bus_valid,
  output logic             bus_fire,
  output logic [BUS_W-1:0] bus_data,
  output logic             fill_zero
);
  logic [SR_W-1:0]   sr_q;
  logic [FILL_W-1:0] fill_q;
  logic [SZ_W-1:0]   p_bits, l_bits;
  logic [FILL_W-1:0] l_ext, p_ext;

  assign p_bits = pix_bits(kind);
  assign l_bits = bus_lines(lanes);
  assign l_ext  = FILL_W'(l_bits);
  assign p_ext  = FILL_W'(p_bits);

  assign fill_zero = (fill_q == '0);
  assign pix_ready = run && !rem_zero && (fill_q < l_ext);
  assign bus_valid = run && !fill_zero && ((fill_q >= l_ext) || rem_zero);
  assign pix_fire  = pix_valid && pix_ready;
  assign bus_fire  = bus_valid && bus_ready;
  assign bus_data  = slice_word(sr_q[SR_W-1 -: BUS_W], l_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (!en) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (pix_fire) begin
      sr_q   <= sr_q | place_px(pix_data, p_bits, fill_q);
      fill_q <= fill_q + p_ext;
    end else if (bus_fire) begin
      sr_q   <= sr_q << l_bits;
      fill_q <= (fill_q > l_ext) ? fill_q - l_ext : '0;
    end
  end

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(SR_W));

  assert_word_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (!run || (bus_valid && $stable(bus_data))));
endmodule

// File: rtl/pixel_bus_packer.sv
module pixel_bus_packer
  import pxpk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [1:0]       cfg_lanes,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             ext_trig,
  input  logic             pix_valid,
  input  logic [23:0]      pix_data,
  output logic             pix_ready,
  output logic             bus_valid,
  output logic [15:0]      bus_data,
  output logic [1:0]       bus_cs,
  input  logic             bus_ready,
  output logic             frame_done,
  output logic [7:0]       ctrl_rd
);
  logic             en, run, start_load, done_evt, rem_zero, fill_zero;
  logic             pix_fire, bus_fire;
  pix_kind_e        kind;
  lanes_e           lanes;
  logic [CNT_W-1:0] count;

  pxpk_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_lanes(cfg_lanes), .cfg_count(cfg_count),
    .ext_trig(ext_trig), .done_evt(done_evt), .en(en), .run(run),
    .start_load(start_load), .cs(bus_cs), .kind(kind), .lanes(lanes),
    .count(count), .ctrl_rd(ctrl_rd)
  );

  pxpk_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_load(start_load), .count(count),
    .pix_fire(pix_fire), .run(run), .fill_zero(fill_zero), .rem_zero(rem_zero),
    .done_evt(done_evt), .frame_done(frame_done)
  );

  pxpk_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .rem_zero(rem_zero),
    .kind(kind), .lanes(lanes), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .pix_fire(pix_fire), .bus_ready(bus_ready),
    .bus_valid(bus_valid), .bus_fire(bus_fire), .bus_data(bus_data),
    .fill_zero(fill_zero)
  );

  assert_valid_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || pix_ready) |-> ctrl_rd[0]);

  assert_fire_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_fire && bus_fire));
endmodule

// File: tb/pixel_bus_packer_tb.sv
`timescale 1ns/1ps
module pixel_bus_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, cfg_we = 1'b0, ext_trig = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [1:0]  cfg_kind = '0, cfg_lanes = '0;
  logic [15:0] cfg_count = '0;
  logic        pix_valid = 1'b0, bus_ready = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_ready, bus_valid, frame_done;
  logic [15:0] bus_data;
  logic [1:0]  bus_cs;
  logic [7:0]  ctrl_rd;

  int vecs = 0, fails = 0, tick = 0;
  logic [23:0] px[64];
  logic [15:0] expq[$];

  always #2.5 clk = ~clk;

  pixel_bus_packer u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_lanes(cfg_lanes), .cfg_count(cfg_count),
    .ext_trig(ext_trig), .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_cs(bus_cs), .bus_ready(bus_ready),
    .frame_done(frame_done), .ctrl_rd(ctrl_rd)
  );

  always @(posedge clk) begin
    tick++;
    if (tick == 150000) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pbits(input int k);
    case (k) 0: return 12; 1: return 16; 2: return 18; default: return 24; endcase
  endfunction
  function automatic int lbits(input int l);
    case (l) 0: return 8; 1: return 9; 2: return 12; default: return 16; endcase
  endfunction

  // reference stream: right-aligned accumulator, cut L bits at a time
  task automatic build_exp(input int k, input int l, input int n);
    logic [63:0] acc = '0;
    int accn = 0;
    int p = pbits(k), ln = lbits(l);
    logic [63:0] lm = (64'd1 << ln) - 1;
    expq.delete();
    for (int i = 0; i < n; i++) begin
      acc = (acc << p) | (64'(px[i]) & ((64'd1 << p) - 1));
      accn += p;
      while (accn >= ln) begin
        expq.push_back(16'((acc >> (accn - ln)) & lm));
        accn -= ln;
      end
    end
    if (accn > 0) expq.push_back(16'((acc << (ln - accn)) & lm));
  endtask

  task automatic run_frame(input int k, input int l, input int n, input bit frc,
                           input logic [1:0] cs, input int rdy, input bit poke, input string tag);
    int idx = 0, wi = 0, cyc = 0, last_hs = -10, done_at = -1;
    bit prev_stall = 0;
    logic [15:0] prev_data = '0;
    logic [7:0] cw = {3'b000, frc, cs, 1'b0, 1'b1};
    for (int i = 0; i < n; i++) px[i] = 24'($urandom);
    build_exp(k, l, n);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 2'(k); cfg_lanes = 2'(l); cfg_count = 16'(n);
    @(negedge clk);
    cfg_we = 0; ctrl_we = 1; ctrl_wdata = cw;
    @(negedge clk);
    ctrl_we = 0;
    #1 chk(ctrl_rd == cw, "R8 ctrl readback", ctrl_rd, cw);
    if (!frc) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); pix_valid = 1; pix_data = px[0]; bus_ready = 1;
        #1 chk(!pix_ready && !bus_valid, "R9 wait for trigger", {pix_ready, bus_valid}, 0);
      end
      pix_valid = 0;
      @(negedge clk); ext_trig = 1;
      @(negedge clk); ext_trig = 0;
    end
    while (cyc < 3000 && done_at < 0) begin
      if (poke) begin
        cfg_we = (cyc == 0); cfg_kind = 2'(k ^ 1); cfg_lanes = 2'(l ^ 2); cfg_count = 16'd1;
      end
      pix_valid = (idx < n) && ($urandom % 100 < 80);
      pix_data  = px[idx < 64 ? idx : 0];
      bus_ready = ($urandom % 100 < rdy);
      #1;
      if (prev_stall)
        chk(bus_valid && bus_data == prev_data, "R12 word held", bus_data, prev_data);
      if (frame_done) begin
        done_at = cyc;
        chk(cyc == last_hs + 2, "R7 done timing", cyc, last_hs + 2);
        chk(ctrl_rd[0] == 1'b0, "R7 enable cleared", ctrl_rd, 0);
        chk(idx == n, "R6 pixel count", idx, n);
        chk(wi == expq.size(), "R6 word count", wi, expq.size());
      end
      if (pix_valid && pix_ready) begin
        if (idx >= n) chk(0, "R6 extra pixel", idx, n);
        idx++;
      end
      if (bus_valid && bus_ready) begin
        if (wi < expq.size()) chk(bus_data == expq[wi], tag, bus_data, expq[wi]);
        else chk(0, tag, bus_data, 0);
        chk(bus_cs == cs, "R8 chip select", bus_cs, cs);
        wi++;
        last_hs = cyc;
      end
      prev_stall = bus_valid && !bus_ready;
      prev_data  = bus_data;
      @(negedge clk);
      cyc++;
    end
    cfg_we = 0; pix_valid = 0; bus_ready = 0;
    if (done_at < 0) chk(0, "R7 frame_done missing", 0, 1);
    #1 chk(!frame_done, "R7 single pulse", frame_done, 0);
  endtask

  task automatic disable_mid_pixel();
    bit got = 0;
    @(negedge clk);
    cfg_we = 1; cfg_kind = 2'd3; cfg_lanes = 2'd0; cfg_count = 16'd4;
    @(negedge clk);
    cfg_we = 0; ctrl_we = 1; ctrl_wdata = 8'h11;
    @(negedge clk);
    ctrl_we = 0;
    for (int i = 0; i < 50 && !got; i++) begin
      pix_valid = 1; pix_data = 24'hA1B2C3; bus_ready = 1;
      #1;
      if (bus_valid && bus_ready) begin
        got = 1;
        chk(bus_data == 16'h00A1, "R11 first slice", bus_data, 16'h00A1);
      end
      @(negedge clk);
    end
    pix_valid = 0; bus_ready = 0; ctrl_we = 1; ctrl_wdata = 8'h00;
    @(negedge clk);
    ctrl_we = 0;
    #1 chk(!bus_valid && !pix_ready && ctrl_rd == 8'h00, "R11 stopped",
           {bus_valid, pix_ready, ctrl_rd}, 0);
  endtask

  initial begin
    int k, l;
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(!bus_valid && !pix_ready && !frame_done && ctrl_rd == 8'h00, "R1 reset state",
           {bus_valid, pix_ready, frame_done, ctrl_rd}, 0);
    run_frame(0, 2, 5, 1, 2'd1, 100, 0, "R2 12-on-12 upper bits ignored");
    run_frame(1, 0, 3, 1, 2'd2, 100, 0, "R3 16-on-8 high then low");
    run_frame(3, 0, 2, 1, 2'd1, 70,  0, "R3 24-on-8 three slices");
    run_frame(0, 0, 4, 1, 2'd1, 60,  0, "R4 12-on-8 paired");
    run_frame(3, 3, 6, 1, 2'd3, 50,  0, "R4 24-on-16 paired");
    run_frame(2, 2, 3, 1, 2'd2, 80,  0, "R5 18-on-12 odd flush");
    run_frame(0, 0, 1, 1, 2'd1, 100, 0, "R5 single pixel flush");
    run_frame(1, 0, 4, 0, 2'd2, 80,  0, "R9 triggered frame");
    run_frame(2, 1, 5, 1, 2'd1, 40,  1, "R10 config poke ignored");
    disable_mid_pixel();
    run_frame(3, 0, 2, 1, 2'd1, 100, 0, "R11 fresh frame after disable");
    for (int r = 0; r < 24; r++) begin
      case ($urandom % 9)
        0: begin k = 0; l = 2; end
        1: begin k = 1; l = 3; end
        2: begin k = 1; l = 0; end
        3: begin k = 3; l = 0; end
        4: begin k = 0; l = 0; end
        5: begin k = 2; l = 2; end
        6: begin k = 3; l = 3; end
        7: begin k = 2; l = 1; end
        default: begin k = 3; l = 2; end
      endcase
      run_frame(k, l, 1 + int'($urandom % 12), 1'($urandom), 2'($urandom), 30 + int'($urandom % 71),
                0, "R3 random slicing");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule